// File: doc/BRIEF.md
# Receive Length Field Checker

This block follows the byte stream of one received Ethernet frame after the preamble and start delimiter have been removed. Every accepted byte, the frame check sequence included, is counted. The two-byte length/type field is captured at its position in the header. When the last byte of the frame is accepted, the block reports the byte count, the captured field and three flags. The flags say whether the field is a type value, whether the frame carries an 802.1Q tag, and whether the length in the field disagrees with the length of the data that actually arrived.

A frame is tagged when tag detection is allowed and bytes 12 and 13 read 0x8100. The length/type field then moves past the four tag bytes. Address filtering and CRC checking are handled elsewhere. The block sees only byte positions and values. Idle cycles inside a frame, where `in_valid` is low, are skipped and not counted.

Top module: `lfc_len_check`

## Requirements
- R1: After reset, `stat_valid`, `stat_count`, `stat_field`, `stat_mismatch`, `stat_is_vlan` and `stat_is_type` are all zero.
- R2: `stat_valid` is high for exactly one cycle. That cycle is the one after each cycle where `in_valid` and `in_last` are both high. It is never high at any other time.
- R3: `stat_count` equals the number of bytes accepted in the frame, counting the last byte. Cycles with `in_valid` low add nothing. The count saturates at 2^CNT_W-1.
- R4: For an untagged frame, `stat_field` is byte 12 (bits 15:8) joined with byte 13 (bits 7:0). Bytes are numbered from 0 at the first byte after the start delimiter.
- R5: A frame is tagged when `vlan_allow` is high and bytes 12 and 13 equal 0x81 and 0x00. For a tagged frame, `stat_is_vlan` is 1, `stat_field` is taken from bytes 16 (bits 15:8) and 17 (bits 7:0), and the header is 18 bytes long instead of 14.
- R6: When `vlan_allow` is low, a value of 0x8100 in bytes 12 and 13 is an ordinary type field: `stat_is_vlan` is 0, `stat_field` is 0x8100 and `stat_is_type` is 1.
- R7: A fully captured field of 0x0600 or more sets `stat_is_type` and clears `stat_mismatch`.
- R8: Below 0x0600, the data length is the count minus the header minus 4. `stat_mismatch` is 0 only in two cases: the data length equals the field, or the field is below 46 and the data length is exactly 46.
- R9: A frame that ends before its field is complete reports zero for each field byte it did not reach. This means fewer than 14 bytes when untagged, or fewer than 18 when tagged. Such a frame reports `stat_is_type` 0 and `stat_mismatch` 1. A frame too short to hold its header and FCS also reports a mismatch.
- R10: All status outputs hold their values between `stat_valid` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A frame byte is presented this cycle |
| in_last | input | 1 | The presented byte is the final byte of the frame |
| in_data | input | 8 | Frame byte |
| vlan_allow | input | 1 | Allows 802.1Q tag detection for the current frame |
| stat_valid | output | 1 | One-cycle strobe: the status of the finished frame is presented |
| stat_count | output | CNT_W | Bytes in the finished frame, FCS included |
| stat_field | output | 16 | Captured length/type field |
| stat_mismatch | output | 1 | The length field disagrees with the received data length |
| stat_is_vlan | output | 1 | The frame was treated as tagged |
| stat_is_type | output | 1 | The field was a type value, so no length check was made |

## Verification
The bench drives frames whose length field exactly matches their data, frames padded to 46 data bytes under a small field, and frames with type values. It adds tagged frames with detection both allowed and refused, frames with arbitrary wrong lengths, and frames cut short inside the header. Together these separate the exact-length rule from the padding rule, the 14-byte header from the 18-byte header, and complete fields from incomplete ones. Random idle cycles inside frames test that only accepted bytes are counted. One frame longer than 65535 bytes tests that the count saturates.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

   // Byte positions are counted from 0 at the first byte after the delimiter
   localparam int unsigned TAG_POS_HI  = 12;
   localparam int unsigned TAG_POS_LO  = 13;
   localparam int unsigned TAG_BYTES   = 4;
   localparam int unsigned HDR_UNTAG   = 14;
   localparam int unsigned HDR_TAGGED  = HDR_UNTAG + TAG_BYTES;

   // Capture view including the byte presented in the current cycle
   typedef struct packed {
      logic [15:0] field;
      logic        complete;
      logic        vlan;
   } lfc_cap_t;

endpackage

// File: rtl/lfc_byte_counter.sv
module lfc_byte_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat,
   input  logic             last,
   output logic [CNT_W-1:0] pos,
   output logic [CNT_W-1:0] total
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   // Count including the current byte, held at the ceiling once reached
   always_comb begin
      if (pos == CNT_MAX) total = CNT_MAX;
      else                total = pos + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pos <= '0;
      else if (beat) pos <= last ? '0 : total;
   end

endmodule

// File: rtl/lfc_field_capture.sv
module lfc_field_capture
   import lfc_pkg::*;
#(
   parameter int unsigned CNT_W        = 16,
   parameter bit          VLAN_SUPPORT = 1'b1,
   parameter logic [15:0] TPID         = 16'h8100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat,
   input  logic             last,
   input  logic [CNT_W-1:0] pos,
   input  logic [CNT_W-1:0] total,
   input  logic [7:0]       data,
   input  logic             vlan_allow,
   output lfc_cap_t         cap
);

   localparam logic [CNT_W-1:0] P_HI   = CNT_W'(TAG_POS_HI);
   localparam logic [CNT_W-1:0] P_LO   = CNT_W'(TAG_POS_LO);
   localparam logic [CNT_W-1:0] P_VHI  = CNT_W'(TAG_POS_HI + TAG_BYTES);
   localparam logic [CNT_W-1:0] P_VLO  = CNT_W'(TAG_POS_LO + TAG_BYTES);
   localparam logic [CNT_W-1:0] N_UNT  = CNT_W'(HDR_UNTAG);
   localparam logic [CNT_W-1:0] N_TAG  = CNT_W'(HDR_TAGGED);

   logic [15:0] plain_q, plain_n;
   logic [15:0] inner_q, inner_n;
   logic        vlan_q,  vlan_n;

   always_comb begin
      plain_n = plain_q;
      if (beat && pos == P_HI) plain_n[15:8] = data;
      if (beat && pos == P_LO) plain_n[7:0]  = data;
   end

   generate
      if (VLAN_SUPPORT) begin : g_tag
         always_comb begin
            vlan_n  = vlan_q;
            inner_n = inner_q;
            if (beat && pos == P_LO)
               vlan_n = vlan_allow && ({plain_q[15:8], data} == TPID);
            if (beat && pos == P_VHI) inner_n[15:8] = data;
            if (beat && pos == P_VLO) inner_n[7:0]  = data;
         end
      end else begin : g_notag
         logic unused_tag;
         assign unused_tag = vlan_allow ^ (|inner_q) ^ vlan_q;
         always_comb begin
            vlan_n  = 1'b0;
            inner_n = '0;
         end
      end
   endgenerate

   always_comb begin
      cap.vlan     = vlan_n;
      cap.field    = vlan_n ? inner_n : plain_n;
      cap.complete = vlan_n ? (total >= N_TAG) : (total >= N_UNT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         plain_q <= '0;
         inner_q <= '0;
         vlan_q  <= 1'b0;
      end else if (beat && last) begin
         plain_q <= '0;
         inner_q <= '0;
         vlan_q  <= 1'b0;
      end else begin
         plain_q <= plain_n;
         inner_q <= inner_n;
         vlan_q  <= vlan_n;
      end
   end

endmodule

// File: rtl/lfc_judge.sv
module lfc_judge
   import lfc_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned MIN_DATA   = 46,
   parameter int unsigned FCS_BYTES  = 4,
   parameter int unsigned TYPE_MIN   = 16'h0600,
   parameter bit          ACCEPT_PAD = 1'b1
) (
   input  lfc_cap_t         cap,
   input  logic [CNT_W-1:0] total,
   output logic             mismatch,
   output logic             is_type
);

   localparam int unsigned AW = (CNT_W > 16) ? CNT_W + 1 : 17;

   logic [AW-1:0] tot_w, need_w, dlen_w, fld_w;
   logic          room, exact, padded;

   always_comb begin
      tot_w  = AW'(total);
      need_w = cap.vlan ? AW'(HDR_TAGGED + FCS_BYTES) : AW'(HDR_UNTAG + FCS_BYTES);
      room   = tot_w >= need_w;
      dlen_w = tot_w - need_w;
      fld_w  = AW'(cap.field);
      exact  = room && (dlen_w == fld_w);
   end

   generate
      if (ACCEPT_PAD) begin : g_pad
         assign padded = room && (fld_w < AW'(MIN_DATA)) && (dlen_w == AW'(MIN_DATA));
      end else begin : g_nopad
         assign padded = 1'b0;
      end
   endgenerate

   always_comb begin
      is_type  = cap.complete && (cap.field >= 16'(TYPE_MIN));
      mismatch = !is_type && !(cap.complete && (exact || padded));
   end

endmodule

// File: rtl/lfc_len_check.sv
module lfc_len_check
   import lfc_pkg::*;
#(
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned MIN_DATA     = 46,
   parameter int unsigned FCS_BYTES    = 4,
   parameter int unsigned TYPE_MIN     = 16'h0600,
   parameter bit          VLAN_SUPPORT = 1'b1,
   parameter bit          ACCEPT_PAD   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_last,
   input  logic [7:0]       in_data,
   input  logic             vlan_allow,
   output logic             stat_valid,
   output logic [CNT_W-1:0] stat_count,
   output logic [15:0]      stat_field,
   output logic             stat_mismatch,
   output logic             stat_is_vlan,
   output logic             stat_is_type
);

   generate
      if (CNT_W < 8 || CNT_W > 32) begin : g_bad_cnt
         $error("lfc_len_check: CNT_W must lie in 8..32");
      end
      if (TYPE_MIN > 16'hFFFF || TYPE_MIN <= MIN_DATA) begin : g_bad_type
         $error("lfc_len_check: TYPE_MIN must fit 16 bits and exceed MIN_DATA");
      end
      if (FCS_BYTES > 8) begin : g_bad_fcs
         $error("lfc_len_check: FCS_BYTES out of range");
      end
   endgenerate

   logic [CNT_W-1:0] pos, total;
   lfc_cap_t         cap;
   logic             mism, typ;
   logic             beat, fin;

   assign beat = in_valid;
   assign fin  = in_valid && in_last;

   lfc_byte_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .beat  (beat),
      .last  (in_last),
      .pos   (pos),
      .total (total)
   );

   lfc_field_capture #(
      .CNT_W        (CNT_W),
      .VLAN_SUPPORT (VLAN_SUPPORT)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat       (beat),
      .last       (in_last),
      .pos        (pos),
      .total      (total),
      .data       (in_data),
      .vlan_allow (vlan_allow),
      .cap        (cap)
   );

   lfc_judge #(
      .CNT_W      (CNT_W),
      .MIN_DATA   (MIN_DATA),
      .FCS_BYTES  (FCS_BYTES),
      .TYPE_MIN   (TYPE_MIN),
      .ACCEPT_PAD (ACCEPT_PAD)
   ) u_judge (
      .cap      (cap),
      .total    (total),
      .mismatch (mism),
      .is_type  (typ)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_valid    <= 1'b0;
         stat_count    <= '0;
         stat_field    <= '0;
         stat_mismatch <= 1'b0;
         stat_is_vlan  <= 1'b0;
         stat_is_type  <= 1'b0;
      end else begin
         stat_valid <= fin;
         if (fin) begin
            stat_count    <= total;
            stat_field    <= cap.field;
            stat_mismatch <= mism;
            stat_is_vlan  <= cap.vlan;
            stat_is_type  <= typ;
         end
      end
   end

endmodule

// File: rtl/lfc_len_check_chk.sv
module lfc_len_check_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_last,
   input logic             stat_valid,
   input logic [CNT_W-1:0] stat_count,
   input logic [15:0]      stat_field,
   input logic             stat_mismatch,
   input logic             stat_is_vlan,
   input logic             stat_is_type
);

   localparam logic [CNT_W-1:0] HDR_MIN = CNT_W'(14);

   // R2
   strobe_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> stat_valid);

   // R2
   strobe_only_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> $past(in_valid && in_last));

   // R3
   count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> stat_count != '0);

   // R5
   tag_needs_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_is_vlan) |-> stat_count >= HDR_MIN);

   // R7
   type_no_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_is_type) |-> !stat_mismatch);

   // R9
   short_frame_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_count < HDR_MIN) |-> (stat_mismatch && !stat_is_type));

   // R10
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_valid |-> ($stable(stat_count) && $stable(stat_field) &&
                       $stable(stat_mismatch) && $stable(stat_is_vlan) &&
                       $stable(stat_is_type)));

endmodule

bind lfc_len_check lfc_len_check_chk #(.CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .in_last       (in_last),
   .stat_valid    (stat_valid),
   .stat_count    (stat_count),
   .stat_field    (stat_field),
   .stat_mismatch (stat_mismatch),
   .stat_is_vlan  (stat_is_vlan),
   .stat_is_type  (stat_is_type)
);

// File: tb/sim_lfc_len_check.sv
module sim_lfc_len_check;

   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid, in_last, vlan_allow;
   logic [7:0]    in_data;
   logic          stat_valid, stat_mismatch, stat_is_vlan, stat_is_type;
   logic [CW-1:0] stat_count;
   logic [15:0]   stat_field;

   int n_run  = 0;
   int n_fail = 0;
   logic [7:0] hb [0:63];

   always #4 clk = ~clk;

   lfc_len_check #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
      .in_data(in_data), .vlan_allow(vlan_allow), .stat_valid(stat_valid),
      .stat_count(stat_count), .stat_field(stat_field),
      .stat_mismatch(stat_mismatch), .stat_is_vlan(stat_is_vlan),
      .stat_is_type(stat_is_type)
   );

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] byte_at(input int i);
      if (i < 64) return hb[i];
      return 8'(i * 7 + 3);
   endfunction

   function automatic void predict(input int n, input bit ven, output int cnt,
                                   output int fld, output bit vl, output bit ty,
                                   output bit mm);
      int  hdr, dl;
      bit  comp;
      cnt = (n > 65535) ? 65535 : n;
      vl  = ven && n >= 14 && hb[12] == 8'h81 && hb[13] == 8'h00;
      if (vl) begin
         fld  = ((n > 16) ? int'(hb[16]) : 0) * 256 + ((n > 17) ? int'(hb[17]) : 0);
         comp = (n >= 18);
         hdr  = 18;
      end else begin
         fld  = ((n > 12) ? int'(hb[12]) : 0) * 256 + ((n > 13) ? int'(hb[13]) : 0);
         comp = (n >= 14);
         hdr  = 14;
      end
      ty = comp && fld >= 'h600;
      dl = cnt - hdr - 4;
      mm = !ty && !(comp && dl >= 0 && (dl == fld || (fld < 46 && dl == 46)));
   endfunction

   task automatic send(input int n, input bit ven, input int idle_pct, input string tag);
      int cnt, fld;
      bit vl, ty, mm, early;
      int held;
      predict(n, ven, cnt, fld, vl, ty, mm);
      early = 1'b0;
      vlan_allow = ven;
      for (int i = 0; i < n; i++) begin
         while (int'($urandom_range(99)) < idle_pct) begin
            @(negedge clk);
            if (stat_valid) early = 1'b1;
            in_valid = 1'b0;
            in_last  = 1'($urandom);
            in_data  = 8'($urandom);
         end
         @(negedge clk);
         if (stat_valid) early = 1'b1;
         in_valid = 1'b1;
         in_data  = byte_at(i);
         in_last  = (i == n - 1);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      check({"R2 strobe ", tag}, int'(stat_valid), 1);
      check({"R2 no early strobe ", tag}, int'(early), 0);
      check({"R3 count ", tag}, int'(stat_count), cnt);
      check({"R4/R5 field ", tag}, int'(stat_field), fld);
      check({"R5 vlan ", tag}, int'(stat_is_vlan), int'(vl));
      check({"R7 type ", tag}, int'(stat_is_type), int'(ty));
      check({"R8/R9 mismatch ", tag}, int'(stat_mismatch), int'(mm));
      held = int'(stat_count);
      @(negedge clk);
      check({"R2 single strobe ", tag}, int'(stat_valid), 0);
      check({"R10 hold ", tag}, int'(stat_count), held);
   endtask

   task automatic fill_hdr();
      for (int i = 0; i < 64; i++) hb[i] = 8'($urandom);
   endtask

   task automatic set_field(input int at, input int v);
      hb[at]     = 8'(v >> 8);
      hb[at + 1] = 8'(v);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : stim
      int k, n, f;
      bit v;
      void'($urandom(32'd1234));
      rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0; vlan_allow = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 valid", int'(stat_valid), 0);
      check("R1 count", int'(stat_count), 0);
      check("R1 field", int'(stat_field), 0);
      check("R1 flags", int'({stat_mismatch, stat_is_vlan, stat_is_type}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Directed corners
      fill_hdr(); set_field(12, 82);     send(100, 0, 0,  "R4 exact");
      fill_hdr(); set_field(12, 10);     send(64,  0, 20, "R8 padded");
      fill_hdr(); set_field(12, 10);     send(28,  0, 0,  "R8 unpadded exact");
      fill_hdr(); set_field(12, 10);     send(40,  0, 0,  "R8 wrong pad");
      fill_hdr(); set_field(12, 'h0800); send(70,  0, 0,  "R7 type");
      fill_hdr(); set_field(12, 'h05FF); send(70,  0, 0,  "R7 below type");
      fill_hdr(); set_field(12, 'h8100); set_field(16, 50); send(72, 1, 10, "R5 tagged");
      send(72, 0, 0, "R6 tag refused");
      fill_hdr(); set_field(12, 'h8100); set_field(16, 50); send(17, 1, 0, "R9 tag cut");
      fill_hdr(); send(5, 0, 0, "R9 tiny");
      fill_hdr(); set_field(12, 0); send(14, 0, 0, "R9 no room");
      fill_hdr(); set_field(12, 0); send(1, 0, 0, "R9 one byte");
      fill_hdr(); set_field(12, 100); send(66000, 0, 0, "R3 saturate");

      // Constrained random frames
      for (int r = 0; r < 200; r++) begin
         fill_hdr();
         k = int'($urandom_range(5));
         v = 1'($urandom);
         case (k)
            0: begin n = int'($urandom_range(64, 150)); set_field(12, n - 18); end
            1: begin f = int'($urandom_range(45)); set_field(12, f);
                     n = $urandom_range(1) ? 64 : f + 18; end
            2: begin n = int'($urandom_range(14, 150)); hb[12] = 8'($urandom_range(6, 255)); end
            3: begin n = int'($urandom_range(68, 150)); set_field(12, 'h8100);
                     set_field(16, n - 22); end
            4: begin n = int'($urandom_range(1, 150)); set_field(12, int'($urandom_range(1535))); end
            default: n = int'($urandom_range(1, 20));
         endcase
         send(n, v, 25, "random");
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule